// File: doc/BRIEF.md
# Operand Address Generation Unit

This unit turns one decoded operand specifier into either a 16-bit effective memory address or a 16-bit operand value. It supports six addressing modes: immediate, register direct, register indirect, indirect with post-increment, indexed (register plus offset) and PC-relative (program counter plus offset). For the post-increment mode it also returns the incremented register value, along with a single-cycle write enable, so that the register file can update the register. The memory and the register file are outside the block.

A request presents a mode code, the selected register's value, the program counter and the 8-bit instruction payload. Immediate, indexed and PC-relative requests can ask for a full 16-bit offset word instead of the payload. That word comes from the instruction stream one or more cycles later. The unit has a three-state sequencer:

- **ST_IDLE**: the unit is ready for a request.
- **ST_WAIT_OFS**: the unit is waiting for the offset word.
- **ST_EMIT**: the result is driven for exactly one cycle.

The transitions are:

- ST_IDLE to ST_EMIT on a short request.
- ST_IDLE to ST_WAIT_OFS on a long request.
- ST_WAIT_OFS to ST_EMIT when the offset word arrives.
- ST_WAIT_OFS stays in ST_WAIT_OFS while no word has arrived.
- ST_EMIT to ST_IDLE always.

All address sums wrap modulo 2^16, and no overflow indication is produced.

Top module: `agu_operand_unit`

## Requirements
- R1: While reset is active, and in the first cycle after it, out_valid and busy are 0 and eff_addr, imm_val, mem_access, wb_en and wb_val are all 0.
- R2: A request is accepted when req_valid is 1 in a cycle where busy is 0. If it needs no offset word, out_valid is 1 in the next cycle only, busy is 1 in that same cycle, and both return to 0 in the cycle after.
- R3: A request needs an offset word only when req_long is 1 and req_mode is 0, 4 or 5. For other modes req_long is ignored. After accepting such a request, busy stays 1 and out_valid stays 0 until ext_valid is sampled 1. out_valid is then 1 for exactly the next cycle.
- R4: req_valid is ignored while busy is 1. ext_valid is ignored unless the unit is waiting for an offset word.
- R5: Mode 0 (immediate) gives imm_val equal to the payload zero-extended to 16 bits, or equal to the offset word for a long request. mem_access is 0 and eff_addr is 0.
- R6: Mode 1 (register direct) gives imm_val equal to reg_val, with mem_access 0 and eff_addr 0.
- R7: Mode 2 (register indirect) gives eff_addr equal to reg_val, with mem_access 1, imm_val 0 and wb_en 0.
- R8: Mode 3 (post-increment) gives eff_addr equal to reg_val and mem_access 1. wb_en is 1 for the single output cycle and wb_val is (reg_val + 1) mod 2^16.
- R9: Mode 4 (indexed) gives eff_addr equal to (reg_val + offset) mod 2^16, with mem_access 1. The offset is the payload sign-extended from bit 7, or the offset word for a long request.
- R10: Mode 5 (PC-relative) gives eff_addr equal to (pc_val + offset) mod 2^16, with mem_access 1 and the same offset rule as R9.
- R11: Modes 6 and 7 are reserved. They complete like short requests, including when req_long is 1, and give a cycle with out_valid 1 and every other result output 0.
- R12: Whenever out_valid is 0, eff_addr, imm_val, wb_val, mem_access and wb_en are 0.
- R13: reg_val, pc_val and payload are sampled in the accepting cycle, and ext_word is sampled in the cycle ext_valid is taken. Later changes to these inputs do not alter the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Operand request strobe |
| req_mode | input | 3 | Addressing mode code (0..5, 6/7 reserved) |
| req_long | input | 1 | Take offset from a following word (modes 0, 4, 5) |
| reg_val | input | 16 | Value of the selected register |
| pc_val | input | 16 | Program counter |
| payload | input | 8 | Low byte of the instruction |
| ext_valid | input | 1 | Offset word present |
| ext_word | input | 16 | Offset word |
| busy | output | 1 | Request in progress; new requests ignored |
| out_valid | output | 1 | Result outputs valid this cycle |
| eff_addr | output | 16 | Effective memory address |
| imm_val | output | 16 | Operand value for non-memory modes |
| mem_access | output | 1 | Result needs a memory access |
| wb_en | output | 1 | Write wb_val back to the register |
| wb_val | output | 16 | Incremented register value |

## Verification
A corrupted sequencer state shows within one cycle as a busy or out_valid pattern that disagrees with the request history. Examples are a result pulse lasting two cycles, a long request that completes without an offset word, or a request that is accepted while busy. A corrupted operand latch does not show until the result cycle, because every result output is held at zero before then. At that cycle it appears as a wrong address or operand for the mode being processed. The bench compares all ports against its reference model on every clock. Because of this, both kinds of fault are reported no later than the emitting cycle of the affected request.

// File: rtl/agu_pkg.sv
package agu_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_WAIT_OFS = 2'd1,
        ST_EMIT     = 2'd2
    } agu_state_t;

    typedef enum logic [2:0] {
        AM_IMM  = 3'd0,
        AM_REG  = 3'd1,
        AM_IND  = 3'd2,
        AM_INC  = 3'd3,
        AM_IDX  = 3'd4,
        AM_SYM  = 3'd5,
        AM_RSV6 = 3'd6,
        AM_RSV7 = 3'd7
    } agu_mode_t;

    // Modes whose offset may come from a following word
    function automatic logic can_take_word(input agu_mode_t m);
        return (m == AM_IMM) || (m == AM_IDX) || (m == AM_SYM);
    endfunction

endpackage

// File: rtl/agu_seq.sv
module agu_seq
    import agu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_needs_word,
    input  logic ext_valid,
    output logic accept,
    output logic ofs_load,
    output logic emit,
    output logic busy
);

    agu_state_t state_q;
    agu_state_t state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    state_d = req_needs_word ? ST_WAIT_OFS : ST_EMIT;
                end
            end
            ST_WAIT_OFS: begin
                if (ext_valid) begin
                    state_d = ST_EMIT;
                end
            end
            ST_EMIT: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // Output logic
    always_comb begin
        accept   = 1'b0;
        ofs_load = 1'b0;
        emit     = 1'b0;
        busy     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                accept = req_valid;
            end
            ST_WAIT_OFS: begin
                busy     = 1'b1;
                ofs_load = ext_valid;
            end
            ST_EMIT: begin
                busy = 1'b1;
                emit = 1'b1;
            end
            default: begin
                busy = 1'b0;
            end
        endcase
    end

    AST_EMIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        emit |=> !emit); // R2

    AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_OFS && !ext_valid) |=> (state_q == ST_WAIT_OFS)); // R3

    AST_WORD_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_OFS && ext_valid) |=> emit); // R3

    AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !accept); // R4

endmodule

// File: rtl/agu_latch.sv
module agu_latch
    import agu_pkg::*;
#(
    parameter int AW = 16,
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic          ofs_load,
    input  agu_mode_t     mode_in,
    input  logic [AW-1:0] reg_in,
    input  logic [AW-1:0] pc_in,
    input  logic [PW-1:0] payload_in,
    input  logic [AW-1:0] word_in,
    output agu_mode_t     mode_q,
    output logic [AW-1:0] reg_q,
    output logic [AW-1:0] pc_q,
    output logic [AW-1:0] ofs_q
);

    localparam int EXT_W = AW - PW;

    logic [AW-1:0] pay_sext;
    logic [AW-1:0] pay_zext;
    logic [AW-1:0] pay_ofs;

    generate
        if (EXT_W > 0) begin : g_widen
            assign pay_sext = {{EXT_W{payload_in[PW-1]}}, payload_in};
            assign pay_zext = {{EXT_W{1'b0}}, payload_in};
        end else begin : g_trunc
            assign pay_sext = payload_in[AW-1:0];
            assign pay_zext = payload_in[AW-1:0];
        end
    endgenerate

    // Immediate constants are unsigned; displacements are signed
    assign pay_ofs = (mode_in == AM_IMM) ? pay_zext : pay_sext;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= AM_IMM;
            reg_q  <= '0;
            pc_q   <= '0;
            ofs_q  <= '0;
        end else if (accept) begin
            mode_q <= mode_in;
            reg_q  <= reg_in;
            pc_q   <= pc_in;
            ofs_q  <= pay_ofs;
        end else if (ofs_load) begin
            ofs_q  <= word_in;
        end
    end

endmodule

// File: rtl/agu_calc.sv
module agu_calc
    import agu_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          emit,
    input  agu_mode_t     mode_q,
    input  logic [AW-1:0] reg_q,
    input  logic [AW-1:0] pc_q,
    input  logic [AW-1:0] ofs_q,
    output logic [AW-1:0] eff_addr,
    output logic [AW-1:0] imm_val,
    output logic          mem_access,
    output logic          wb_en,
    output logic [AW-1:0] wb_val
);

    localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

    logic [AW-1:0] base;
    logic [AW-1:0] sum;

    // One shared adder; the base is selected by mode, the sum wraps
    assign base = (mode_q == AM_SYM) ? pc_q : reg_q;
    assign sum  = base + ofs_q;

    always_comb begin
        eff_addr   = '0;
        imm_val    = '0;
        mem_access = 1'b0;
        wb_en      = 1'b0;
        wb_val     = '0;
        if (emit) begin
            unique case (mode_q)
                AM_IMM: imm_val = ofs_q;
                AM_REG: imm_val = reg_q;
                AM_IND: begin
                    eff_addr   = reg_q;
                    mem_access = 1'b1;
                end
                AM_INC: begin
                    eff_addr   = reg_q;
                    mem_access = 1'b1;
                    wb_en      = 1'b1;
                    wb_val     = reg_q + ONE;
                end
                AM_IDX, AM_SYM: begin
                    eff_addr   = sum;
                    mem_access = 1'b1;
                end
                AM_RSV6, AM_RSV7: begin
                    eff_addr = '0;
                end
                default: begin
                    eff_addr = '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/agu_operand_unit.sv
module agu_operand_unit
    import agu_pkg::*;
#(
    parameter int AW = 16,
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [2:0]    req_mode,
    input  logic          req_long,
    input  logic [AW-1:0] reg_val,
    input  logic [AW-1:0] pc_val,
    input  logic [PW-1:0] payload,
    input  logic          ext_valid,
    input  logic [AW-1:0] ext_word,
    output logic          busy,
    output logic          out_valid,
    output logic [AW-1:0] eff_addr,
    output logic [AW-1:0] imm_val,
    output logic          mem_access,
    output logic          wb_en,
    output logic [AW-1:0] wb_val
);

    localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

    agu_mode_t     mode_in;
    agu_mode_t     mode_q;
    logic          needs_word;
    logic          accept;
    logic          ofs_load;
    logic          emit;
    logic [AW-1:0] reg_q;
    logic [AW-1:0] pc_q;
    logic [AW-1:0] ofs_q;

    assign mode_in    = agu_mode_t'(req_mode);
    assign needs_word = req_long && can_take_word(mode_in);

    agu_seq u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid      (req_valid),
        .req_needs_word (needs_word),
        .ext_valid      (ext_valid),
        .accept         (accept),
        .ofs_load       (ofs_load),
        .emit           (emit),
        .busy           (busy)
    );

    agu_latch #(.AW(AW), .PW(PW)) u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .ofs_load   (ofs_load),
        .mode_in    (mode_in),
        .reg_in     (reg_val),
        .pc_in      (pc_val),
        .payload_in (payload),
        .word_in    (ext_word),
        .mode_q     (mode_q),
        .reg_q      (reg_q),
        .pc_q       (pc_q),
        .ofs_q      (ofs_q)
    );

    agu_calc #(.AW(AW)) u_calc (
        .emit       (emit),
        .mode_q     (mode_q),
        .reg_q      (reg_q),
        .pc_q       (pc_q),
        .ofs_q      (ofs_q),
        .eff_addr   (eff_addr),
        .imm_val    (imm_val),
        .mem_access (mem_access),
        .wb_en      (wb_en),
        .wb_val     (wb_val)
    );

    assign out_valid = emit;

    AST_VALID_IS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> busy); // R2

    AST_QUIET_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (eff_addr == '0 && imm_val == '0 && wb_val == '0 && !mem_access && !wb_en)); // R12

    AST_WB_PLUS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> (wb_val == eff_addr + ONE)); // R8

    AST_WB_WITH_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> (mem_access && out_valid)); // R8

    AST_SHORT_EMITS: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid && !needs_word) |=> out_valid); // R2

    AST_NO_MEM_ON_IMM: assert property (@(posedge clk) disable iff (!rst_n)
        (imm_val != '0) |-> !mem_access); // R5

endmodule

// File: tb/tb_agu_operand_unit.sv
module tb_agu_operand_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_mode = 3'd0;
    logic        req_long = 1'b0;
    logic [15:0] reg_val = 16'h0;
    logic [15:0] pc_val = 16'h0;
    logic [7:0]  payload = 8'h0;
    logic        ext_valid = 1'b0;
    logic [15:0] ext_word = 16'h0;
    logic        busy, out_valid, mem_access, wb_en;
    logic [15:0] eff_addr, imm_val, wb_val;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    string ctx = "R1";

    always #10 clk = ~clk;

    agu_operand_unit dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
        .req_long(req_long), .reg_val(reg_val), .pc_val(pc_val), .payload(payload),
        .ext_valid(ext_valid), .ext_word(ext_word), .busy(busy), .out_valid(out_valid),
        .eff_addr(eff_addr), .imm_val(imm_val), .mem_access(mem_access), .wb_en(wb_en),
        .wb_val(wb_val)
    );

    // Reference model: phase 0 idle, 1 waiting for word, 2 result cycle
    int          ph = 0;
    int          m_mode = 0;
    int unsigned m_reg = 0, m_pc = 0, m_ofs = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            ph <= 0;
        end else begin
            case (ph)
                0: if (req_valid) begin
                    m_mode <= int'(req_mode);
                    m_reg  <= reg_val;
                    m_pc   <= pc_val;
                    if (req_long && (req_mode == 0 || req_mode == 4 || req_mode == 5))
                        ph <= 1;
                    else begin
                        if (req_mode == 0) m_ofs <= payload;
                        else m_ofs <= payload[7] ? (32'hFF00 | payload) : payload;
                        ph <= 2;
                    end
                end
                1: if (ext_valid) begin
                    m_ofs <= ext_word;
                    ph <= 2;
                end
                default: ph <= 0;
            endcase
        end
    end

    function automatic string mode_tag(int m);
        case (m)
            0: return "R5";
            1: return "R6";
            2: return "R7";
            3: return "R8";
            4: return "R9";
            5: return "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic chk(string name, string tag, int unsigned act, int unsigned exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h at %0t", tag, name, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            int unsigned e_ea, e_imm, e_wbv;
            bit e_mem, e_wbe, e_val, e_busy;
            string dtag;
            e_ea = 0; e_imm = 0; e_wbv = 0; e_mem = 0; e_wbe = 0;
            e_val  = (ph == 2);
            e_busy = (ph != 0);
            if (e_val) begin
                case (m_mode)
                    0: e_imm = m_ofs;
                    1: e_imm = m_reg;
                    2: begin e_ea = m_reg; e_mem = 1; end
                    3: begin e_ea = m_reg; e_mem = 1; e_wbe = 1; e_wbv = (m_reg + 1) & 32'hFFFF; end
                    4: begin e_ea = (m_reg + m_ofs) & 32'hFFFF; e_mem = 1; end
                    5: begin e_ea = (m_pc + m_ofs) & 32'hFFFF; e_mem = 1; end
                    default: ;
                endcase
                dtag = mode_tag(m_mode);
            end else begin
                dtag = (ctx == "R1") ? "R1" : "R12";
            end
            chk("out_valid", ctx, out_valid, e_val);
            chk("busy", ctx, busy, e_busy);
            chk("eff_addr", dtag, eff_addr, e_ea);
            chk("imm_val", dtag, imm_val, e_imm);
            chk("mem_access", dtag, mem_access, e_mem);
            chk("wb_en", dtag, wb_en, e_wbe);
            chk("wb_val", dtag, wb_val, e_wbv);
        end
    end

    task automatic request(int m, bit lng, int unsigned r, int unsigned p, int unsigned pay);
        req_valid = 1; req_mode = 3'(m); req_long = lng;
        reg_val = 16'(r); pc_val = 16'(p); payload = 8'(pay);
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic word(int unsigned w);
        ext_valid = 1; ext_word = 16'(w);
        @(negedge clk);
        ext_valid = 0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        ctx = "R1";
        idle(4);
        rst_n = 1;
        idle(2);

        // R2 short requests, one per mode (R5..R10), wrap cases
        ctx = "R2";
        request(0, 0, 16'h1111, 16'h2222, 8'hA5); idle(2);   // R5 zero-extend
        request(1, 0, 16'hC3C3, 16'h0, 8'h00); idle(2);       // R6
        request(2, 0, 16'h4000, 16'h0, 8'h7F); idle(2);       // R7
        request(3, 0, 16'hFFFF, 16'h0, 8'h00); idle(2);       // R8 wrap to 0
        request(3, 0, 16'h0041, 16'h0, 8'h00); idle(2);       // R8
        request(4, 0, 16'h0010, 16'h0, 8'hF0); idle(2);       // R9 negative offset
        request(5, 0, 16'h0, 16'hFFFE, 8'h05); idle(2);       // R10 wrap
        request(4, 0, 16'h0100, 16'h0, 8'h80); idle(2);       // R9 -128
        // back-to-back: second request lands in the result cycle (R4)
        ctx = "R4";
        request(2, 0, 16'h0AAA, 16'h0, 8'h0);
        request(1, 0, 16'h5555, 16'h0, 8'h0); idle(2);
        ext_valid = 1; ext_word = 16'hDEAD; idle(2); ext_valid = 0;  // R4 stray word

        // R3 long requests with variable wait, stray requests while waiting (R4)
        ctx = "R3";
        request(0, 1, 16'h0, 16'h0, 8'h12); idle(3); word(16'hBEEF); idle(2);
        request(4, 1, 16'h1234, 16'h0, 8'h00); word(16'h8000); idle(2);
        request(5, 1, 16'h0, 16'hF000, 8'h00); idle(1); word(16'h2001); idle(2);
        request(2, 1, 16'h7777, 16'h0, 8'h00); idle(2);      // long ignored for mode 2
        ctx = "R4";
        request(4, 1, 16'h0002, 16'h0, 8'h00);
        request(1, 0, 16'h9999, 16'h0, 8'h00);                // ignored while busy
        idle(1); word(16'h0003); idle(2);
        // R13 inputs move after acceptance
        ctx = "R13";
        request(5, 1, 16'h0, 16'h1000, 8'h00);
        pc_val = 16'h2000; reg_val = 16'hFFFF; payload = 8'h44; idle(2);
        ext_valid = 1; ext_word = 16'h0010; @(negedge clk); ext_valid = 0;
        ext_word = 16'h7777; idle(2);
        // R11 reserved codes, with and without req_long
        ctx = "R11";
        request(6, 1, 16'h1234, 16'h5678, 8'h9A); idle(2);
        request(7, 0, 16'hFFFF, 16'hFFFF, 8'hFF); idle(2);

        // Mixed random traffic
        ctx = "R2";
        for (int i = 0; i < 400; i++) begin
            req_valid = ($urandom_range(0, 3) != 0);
            req_mode  = 3'($urandom_range(0, 7));
            req_long  = 1'($urandom_range(0, 1));
            reg_val   = 16'($urandom);
            pc_val    = 16'($urandom);
            payload   = 8'($urandom);
            ext_valid = ($urandom_range(0, 2) == 0);
            ext_word  = 16'($urandom);
            @(negedge clk);
        end
        req_valid = 0; ext_valid = 1; idle(3); ext_valid = 0; idle(2);
        finish_run();
    end

endmodule